// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt Unit

This unit watches every pin in two 32-pin banks and records pin events in sticky status bits. Each pin has six detect sources, each with its own enable. Four sources work on the synchronized pin sample: rising edge, falling edge, high level and low level. Two sources work on the raw pin: an asynchronous rising edge and an asynchronous falling edge. A pin may have any mix of these sources enabled at once. A detected event sets the pin's status bit. Software clears a status bit by writing a one to it. While any status bit in either bank is set, the single registered interrupt line is high.

The register bus uses a simple write strobe, a byte address and 32-bit write data. Read data is combinational from the address. Within each register group, bank 0 sits at the group base and bank 1 at the base plus 4.

A level source that stays enabled keeps setting its bit, so the bit comes back at once after a clear while the level lasts. An asynchronous edge is first caught by a flop clocked from the raw pin. It then passes through a synchronizer before it reaches the status register. This lets a pulse shorter than one system clock still be recorded.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset every enable register, both status registers and `irq_o` are zero.
- R2: Register byte addresses, for bank b in {0,1}, are:
  - status at 0x40+4b;
  - rising enable at 0x4C+4b;
  - falling enable at 0x58+4b;
  - high enable at 0x64+4b;
  - low enable at 0x70+4b;
  - asynchronous rising enable at 0x7C+4b;
  - asynchronous falling enable at 0x88+4b.
  
  Bit i of a bank register belongs to pin 32b+i. Enable registers read back what was written. Any other address reads zero and ignores writes.
- R3: With its rising enable set, a 0-to-1 change of a synchronized pin sets its status bit one clock after the change is sampled. Without the enable, the change has no effect on status.
- R4: With its falling enable set, a 1-to-0 change of a synchronized pin sets its status bit. A rising change does not set it.
- R5: With its high enable set, the status bit is set on every clock while the synchronized pin is 1. A clear written while the level persists leaves the bit set.
- R6: With its low enable set, the status bit is set on every clock while the synchronized pin is 0.
- R7: With its asynchronous rising enable set, a rising edge on the raw pin sets the status bit within four clocks, even for a pulse shorter than a clock. A raw edge that occurs while the enable is clear is never recorded, even if the enable is set later.
- R8: With its asynchronous falling enable set, a falling edge on the raw pin sets the status bit within four clocks. A raw rising edge does not set it.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Writing all ones clears that bank only.
- R10: When an event and a clear hit the same status bit in the same clock, the bit ends up set.
- R11: `irq_o` equals, one clock later, the OR of all status bits of both banks.
- R12: Clearing an enable does not clear a status bit that is already pending.
- R13: Several sources may be enabled on one pin. With rising and falling both enabled, each direction of change sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for `bus_addr_i` |
| pin_sync_i | input | 64 | Pin samples already synchronized to `clk_i` |
| pin_raw_i | input | 64 | Unsynchronized pin levels for asynchronous edge capture |
| irq_o | output | 1 | Registered OR of all status bits |

## Verification
Directed cases place one pin at a time under a single source. This separates the edge sources from the level sources: after a clear, an edge bit stays clear, while a level bit is set again at once.

Further directed cases cover:
- a clear that lands in the same clock as an edge;
- a pin with both edge directions enabled;
- a write of zeros to status;
- an all-ones write, which must leave the other bank untouched.

A constrained-random stretch mixes sparse pin toggles, sparse enable masks over the four synchronous sources and random clear masks. A cycle-level model checks it, which exposes wrong edge polarity, wrong bank decode or a lost set-versus-clear priority.

Raw pulses shorter than a clock, with the asynchronous enables on and off, show whether the raw-pin capture works and whether stale edges stay ignored.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
  localparam int BANK_W       = 32;
  localparam int STAT_BASE    = 'h40;
  localparam int BANK_STRIDE  = 4;
  localparam int GROUP_STRIDE = 12;
  localparam int NUM_KINDS    = 6;

  typedef enum logic [2:0] {
    K_RISE  = 3'd0,
    K_FALL  = 3'd1,
    K_HIGH  = 3'd2,
    K_LOW   = 3'd3,
    K_ARISE = 3'd4,
    K_AFALL = 3'd5
  } det_kind_e;

  typedef struct packed {
    logic [BANK_W-1:0] afall;
    logic [BANK_W-1:0] arise;
    logic [BANK_W-1:0] low;
    logic [BANK_W-1:0] high;
    logic [BANK_W-1:0] fall;
    logic [BANK_W-1:0] rise;
  } bank_en_t;

  // group 0 is status, group k+1 is enable kind k
  function automatic int reg_addr(int group, int bank);
    return STAT_BASE + group * GROUP_STRIDE + bank * BANK_STRIDE;
  endfunction
endpackage

// File: rtl/gpio_evt_regs.sv
`timescale 1ns/1ps
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BANK_W-1:0]           bus_wdata_i,
  output logic [BANK_W-1:0]           bus_rdata_o,
  input  logic [NUM_BANKS*BANK_W-1:0] status_i,
  output bank_en_t [NUM_BANKS-1:0]    en_o,
  output logic [NUM_BANKS*BANK_W-1:0] clr_o
);
  logic [NUM_KINDS-1:0][NUM_BANKS-1:0][BANK_W-1:0] en_q;
  logic [NUM_KINDS:0][NUM_BANKS-1:0]               hit;

  for (genvar g = 0; g <= NUM_KINDS; g++) begin : g_grp
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(reg_addr(g, b));
      assign hit[g][b] = (bus_addr_i == ADDR);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (bus_we_i) begin
      for (int k = 0; k < NUM_KINDS; k++)
        for (int b = 0; b < NUM_BANKS; b++)
          if (hit[k+1][b]) en_q[k][b] <= bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (hit[0][b]) bus_rdata_o = status_i[b*BANK_W +: BANK_W];
    for (int k = 0; k < NUM_KINDS; k++)
      for (int b = 0; b < NUM_BANKS; b++)
        if (hit[k+1][b]) bus_rdata_o = en_q[k][b];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_out
    assign clr_o[b*BANK_W +: BANK_W] = (bus_we_i && hit[0][b]) ? bus_wdata_i : '0;
    assign en_o[b].rise  = en_q[K_RISE][b];
    assign en_o[b].fall  = en_q[K_FALL][b];
    assign en_o[b].high  = en_q[K_HIGH][b];
    assign en_o[b].low   = en_q[K_LOW][b];
    assign en_o[b].arise = en_q[K_ARISE][b];
    assign en_o[b].afall = en_q[K_AFALL][b];
  end
endmodule

// File: rtl/gpio_evt_async_edge.sv
`timescale 1ns/1ps
module gpio_evt_async_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o,
  output logic fall_o
);
  logic                 rise_tgl_q, fall_tgl_q;
  logic [SYNC_STAGES:0] rise_sync_q, fall_sync_q;

  // toggles clocked by the raw pin record an edge of any width
  always_ff @(posedge raw_i or negedge rst_ni) begin
    if (!rst_ni) rise_tgl_q <= 1'b0;
    else         rise_tgl_q <= ~rise_tgl_q;
  end

  always_ff @(negedge raw_i or negedge rst_ni) begin
    if (!rst_ni) fall_tgl_q <= 1'b0;
    else         fall_tgl_q <= ~fall_tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_sync_q <= '0;
      fall_sync_q <= '0;
    end else begin
      rise_sync_q <= {rise_sync_q[SYNC_STAGES-1:0], rise_tgl_q};
      fall_sync_q <= {fall_sync_q[SYNC_STAGES-1:0], fall_tgl_q};
    end
  end

  assign rise_o = rise_sync_q[SYNC_STAGES] ^ rise_sync_q[SYNC_STAGES-1];
  assign fall_o = fall_sync_q[SYNC_STAGES] ^ fall_sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_en_t          en_i,
  input  logic [BANK_W-1:0] sync_i,
  input  logic [BANK_W-1:0] raw_i,
  output logic [BANK_W-1:0] set_o
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] a_rise, a_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar p = 0; p < BANK_W; p++) begin : g_pin
    gpio_evt_async_edge #(.SYNC_STAGES(SYNC_STAGES)) u_async (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_i[p]),
      .rise_o (a_rise[p]),
      .fall_o (a_fall[p])
    );
  end

  assign set_o = ( sync_i & ~prev_q & en_i.rise)
               | (~sync_i &  prev_q & en_i.fall)
               | ( sync_i & en_i.high)
               | (~sync_i & en_i.low)
               | (a_rise  & en_i.arise)
               | (a_fall  & en_i.afall);
endmodule

// File: rtl/gpio_evt_status.sv
`timescale 1ns/1ps
module gpio_evt_status #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] status_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;  // set beats clear
      irq_q    <= |status_q;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/gpio_evt_unit.sv
`timescale 1ns/1ps
module gpio_evt_unit
  import gpio_evt_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BANK_W-1:0]           bus_wdata_i,
  output logic [BANK_W-1:0]           bus_rdata_o,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_sync_i,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_raw_i,
  output logic                        irq_o
);
  localparam int NUM_PINS = NUM_BANKS * BANK_W;

  bank_en_t [NUM_BANKS-1:0] en;
  logic [NUM_PINS-1:0]      set_flat, clr_flat, status_flat;

  gpio_evt_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .status_i    (status_flat),
    .en_o        (en),
    .clr_o       (clr_flat)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_evt_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[b]),
      .sync_i (pin_sync_i[b*BANK_W +: BANK_W]),
      .raw_i  (pin_raw_i[b*BANK_W +: BANK_W]),
      .set_o  (set_flat[b*BANK_W +: BANK_W])
    );
  end

  gpio_evt_status #(.WIDTH(NUM_PINS)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_flat),
    .clr_i    (clr_flat),
    .status_o (status_flat),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/gpio_evt_checker.sv
`timescale 1ns/1ps
module gpio_evt_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] set_i,
  input logic [WIDTH-1:0] clr_i,
  input logic [WIDTH-1:0] status_i,
  input logic             irq_i
);
  assert_reset_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (status_i == '0 && !irq_i));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_i & $past(set_i)) == $past(set_i)));

  assert_w1c_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_i & $past(clr_i) & ~$past(set_i)) == '0));

  assert_pending_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_i) & ~$past(clr_i) & ~status_i) == '0));

  assert_no_spurious_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(set_i)) == '0));

  assert_irq_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_i) |=> irq_i);

  assert_irq_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|status_i) |=> !irq_i);
endmodule

bind gpio_evt_unit gpio_evt_checker #(.WIDTH(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .set_i    (set_flat),
  .clr_i    (clr_flat),
  .status_i (status_flat),
  .irq_i    (irq_o)
);

// File: tb/sim_gpio_evt_unit.sv
`timescale 1ns/1ps
module sim_gpio_evt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] ps = '0;
  logic [63:0] pr = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit model_on = 1'b1;

  logic [63:0]       m_st = '0, m_prev = '0;
  logic [5:0][63:0]  m_en = '0;
  logic              m_irq = 1'b0;

  always #2.5 clk = ~clk;

  gpio_evt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_sync_i(ps),
    .pin_raw_i(pr), .irq_o(irq)
  );

  function automatic logic [7:0] ra(int grp, int bank);
    return 8'('h40 + 12 * grp + 4 * bank);
  endfunction

  function automatic logic [63:0] exp_set(logic [63:0] s, logic [63:0] p, logic [5:0][63:0] e);
    return (s & ~p & e[0]) | (~s & p & e[1]) | (s & e[2]) | (~s & e[3]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [63:0] s, clr, st_n;
    logic [5:0][63:0] en_n;
    logic irq_n;
    s = ps;
    clr = '0;
    en_n = m_en;
    if (we) begin
      for (int b = 0; b < 2; b++) begin
        if (addr == ra(0, b)) clr[32*b +: 32] = wdata;
        for (int k = 0; k < 6; k++)
          if (addr == ra(k + 1, b)) en_n[k][32*b +: 32] = wdata;
      end
    end
    st_n  = (m_st & ~clr) | exp_set(s, m_prev, m_en);
    irq_n = |m_st;
    @(posedge clk);
    #1;
    m_st = st_n; m_en = en_n; m_irq = irq_n; m_prev = s;
    if (model_on) chk("R11 irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.2;
    d = rdata;
  endtask

  task automatic cmp_model(string req);
    logic [31:0] d;
    for (int b = 0; b < 2; b++) begin
      rd(ra(0, b), d);
      chk(req, d, m_st[32*b +: 32]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int g = 0; g < 7; g++)
      for (int b = 0; b < 2; b++) begin
        rd(ra(g, b), d);
        chk("R1 reg zero", d, 32'h0);
      end
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 decode and readback
    wr(8'h4C, 32'hA5A5_0001);
    wr(8'h8C, 32'h1234_5678);
    wr(8'h50, 32'h0F0F_F0F0);
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h4C, d); chk("R2 rise b0", d, 32'hA5A5_0001);
    rd(8'h8C, d); chk("R2 afall b1", d, 32'h1234_5678);
    rd(8'h50, d); chk("R2 rise b1", d, 32'h0F0F_F0F0);
    rd(8'h58, d); chk("R2 fall b0", d, 32'h0);
    rd(8'h48, d); chk("R2 unmapped", d, 32'h0);
    wr(8'h4C, 0); wr(8'h8C, 0); wr(8'h50, 0);
    cmp_model("R2 status");

    // R3 rising edge, R9 clear, R11 irq
    wr(8'h4C, 32'h1);
    ps[0] = 1'b1; ps[1] = 1'b1;
    tick();
    rd(8'h40, d); chk("R3 rise set", d, 32'h1);
    tick();
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    wr(8'h40, 32'h1);
    rd(8'h40, d); chk("R9 w1c", d, 32'h0);
    tick();
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    ps[0] = 1'b0;
    tick();
    rd(8'h40, d); chk("R3 fall ignored", d, 32'h0);

    // R4 falling edge
    wr(8'h5C, 32'h8);
    ps[35] = 1'b1; tick();
    rd(8'h44, d); chk("R4 rise ignored", d, 32'h0);
    ps[35] = 1'b0; tick();
    rd(8'h44, d); chk("R4 fall set", d, 32'h8);
    wr(8'h44, 32'h8);
    rd(8'h44, d); chk("R9 w1c b1", d, 32'h0);

    // R5 high level re-sets after clear
    wr(8'h68, 32'h20);
    ps[37] = 1'b1; tick();
    rd(8'h44, d); chk("R5 high set", d, 32'h20);
    wr(8'h44, 32'h20);
    rd(8'h44, d); chk("R5 level persists", d, 32'h20);
    ps[37] = 1'b0; tick();
    rd(8'h44, d); chk("R5 sticky", d, 32'h20);
    wr(8'h44, 32'h20);
    rd(8'h44, d); chk("R5 cleared", d, 32'h0);
    wr(8'h68, 0);

    // R6 low level
    wr(8'h70, 32'h80);
    tick();
    rd(8'h40, d); chk("R6 low set", d, 32'h80);
    ps[7] = 1'b1; tick();
    wr(8'h40, 32'h80);
    rd(8'h40, d); chk("R6 cleared", d, 32'h0);
    wr(8'h70, 0);

    // R10 edge and clear in same clock
    wr(8'h4C, 32'h4);
    ps[2] = 1'b1;
    wr(8'h40, 32'h4);
    rd(8'h40, d); chk("R10 set wins", d, 32'h4);

    // R12 disabling keeps pending
    wr(8'h4C, 0);
    rd(8'h40, d); chk("R12 pending kept", d, 32'h4);
    wr(8'h40, 32'h4);

    // R13 both edges on one pin
    wr(8'h4C, 32'h200); wr(8'h58, 32'h200);
    ps[9] = 1'b1; tick();
    rd(8'h40, d); chk("R13 rise", d, 32'h200);
    wr(8'h40, 32'h200);
    rd(8'h40, d); chk("R13 cleared", d, 32'h0);
    ps[9] = 1'b0; tick();
    rd(8'h40, d); chk("R13 fall", d, 32'h200);
    wr(8'h40, 32'h200);
    wr(8'h4C, 0); wr(8'h58, 0);

    // R9 write zero, bank isolation
    wr(8'h70, 32'hF000_0000); wr(8'h74, 32'h0000_F000);
    tick();
    wr(8'h70, 0); wr(8'h74, 0);
    rd(8'h40, d); chk("R9 b0 pend", d, 32'hF000_0000);
    rd(8'h44, d); chk("R9 b1 pend", d, 32'h0000_F000);
    wr(8'h40, 32'h0);
    rd(8'h40, d); chk("R9 w0 unchanged", d, 32'hF000_0000);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R9 all ones", d, 32'h0);
    rd(8'h44, d); chk("R9 other bank", d, 32'h0000_F000);
    wr(8'h44, 32'hFFFF_FFFF);
    cmp_model("R9 model");

    // random mix over synchronous sources
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 8)
        0: wr(ra(1 + int'($urandom % 4), int'($urandom % 2)), $urandom & $urandom & $urandom);
        1: wr(ra(0, int'($urandom % 2)), $urandom);
        2: wr(ra(0, int'($urandom % 2)), 32'hFFFF_FFFF);
        default: begin
          ps = ps ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
          tick();
        end
      endcase
      if (i % 6 == 0) cmp_model("R3 R4 R5 R6 random");
    end
    for (int k = 1; k < 7; k++)
      for (int b = 0; b < 2; b++) wr(ra(k, b), 0);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF);
    cmp_model("R9 flush");

    // asynchronous edges
    model_on = 1'b0;
    wr(8'h7C, 32'h1000);
    pr[12] = 1'b1; #0.5; pr[12] = 1'b0;
    repeat (4) tick();
    rd(8'h40, d); chk("R7 short pulse", d, 32'h1000);
    tick();
    chk("R11 irq async", {31'b0, irq}, 32'h1);
    wr(8'h40, 32'h1000);
    rd(8'h40, d); chk("R7 cleared", d, 32'h0);
    pr[13] = 1'b1; #0.5; pr[13] = 1'b0;
    repeat (4) tick();
    rd(8'h40, d); chk("R7 disabled pin", d, 32'h0);
    wr(8'h7C, 32'h3000);
    repeat (4) tick();
    rd(8'h40, d); chk("R7 stale edge", d, 32'h0);
    wr(8'h8C, 32'h1);
    pr[32] = 1'b1;
    repeat (4) tick();
    rd(8'h44, d); chk("R8 rise ignored", d, 32'h0);
    pr[32] = 1'b0;
    repeat (4) tick();
    rd(8'h44, d); chk("R8 fall set", d, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule